// File: doc/BRIEF.md
# Trace-Write Instruction Gate

This block sits behind an instruction decoder and handles one instruction class: an instruction that lets user code push a value into the hardware trace stream. While a decoded instruction is presented, the block checks whether it belongs to this class and whether it is legal. It then decides whether a payload packet goes to the trace encoder, with what size, and whether a companion instruction-pointer packet follows.

Packets leave through two valid/ready channels. The payload packet always goes first. The IP packet is offered only after the payload packet has been accepted. When the instruction finishes, `done` pulses for one cycle. An undefined-opcode fault is reported in that same cycle.

The requester holds every instruction input steady from `instValid` until `done`. It drops `instValid` in the `done` cycle.

Top module: `trace_write_gate`

## Requirements
- R1: An instruction is handled only when the opcode bytes are 0xF3, 0x0F, 0xAE (first to third) and the ModRM reg field is 4. Any other instruction gets no fault, no packet and no `done`.
- R2: `pktSize` is 1 (8 bytes, full 64-bit `operand`) only when `rexW` and `mode64` are both 1. Otherwise `pktSize` is 0 (4 bytes), and `pktData` holds `operand[31:0]` with bits 63:32 zero. This includes `rexW` outside 64-bit mode.
- R3: A legal instruction issues a payload packet only when `trigEn`, `ctxEn`, `filtEn` and `twEn` are all 1. Otherwise it completes with `done` and no packet.
- R4: A `lockPfx` prefix, an `opsizePfx` (66H) prefix, or `featEn` = 0 makes a recognized instruction fault. `udFault` is 1 in the `done` cycle, and no packet is issued.
- R5: The fault decision takes priority over trace gating. A faulting instruction issues no packet even with all four enables set.
- R6: `pktIpFlag` equals `fupOnTw`. When `fupOnTw` is 1, an IP packet carrying `instPtr` is offered on the cycle after the payload packet is accepted, never earlier and never at the same time.
- R7: While a valid is high and its ready is low, the valid stays high and its data and size stay unchanged.
- R8: `done` is a single-cycle pulse. It comes one cycle after the last packet acceptance, or one cycle after the instruction is taken when no packet is issued.
- R9: After reset, `pktValid`, `ipValid`, `done` and `udFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Decoded instruction presented |
| opByte0 | input | 8 | First opcode byte (mandatory prefix) |
| opByte1 | input | 8 | Second opcode byte (escape) |
| opByte2 | input | 8 | Third opcode byte |
| modrmReg | input | 3 | ModRM reg field |
| rexW | input | 1 | REX.W present |
| opsizePfx | input | 1 | 66H operand-size prefix present |
| lockPfx | input | 1 | LOCK prefix present |
| mode64 | input | 1 | Core in 64-bit mode |
| featEn | input | 1 | Trace-write feature supported |
| trigEn | input | 1 | Trace trigger enable |
| ctxEn | input | 1 | Trace context enable |
| filtEn | input | 1 | Trace filter enable |
| twEn | input | 1 | Trace-write packet enable |
| fupOnTw | input | 1 | Request IP packet with each trace write |
| operand | input | 64 | Source operand value |
| instPtr | input | 64 | Address of this instruction |
| pktValid | output | 1 | Payload packet offered |
| pktReady | input | 1 | Payload packet accepted |
| pktData | output | 64 | Payload |
| pktSize | output | 1 | 0 = 4 bytes, 1 = 8 bytes |
| pktIpFlag | output | 1 | IP-follows flag carried by the packet |
| ipValid | output | 1 | IP packet offered |
| ipReady | input | 1 | IP packet accepted |
| ipAddr | output | 64 | IP packet address |
| done | output | 1 | Instruction finished (one cycle) |
| udFault | output | 1 | Undefined-opcode fault, valid with done |

## Verification
A wrong state in the sequencer shows up at the ports within one cycle of the instruction being taken. Symptoms include a payload packet on a gated-off or faulting instruction, an IP packet overlapping or preceding the payload, or a `done` that repeats or never arrives. A wrong captured size or mask shows up on the first payload offer: either nonzero upper bits with size 0, or a 64-bit payload outside 64-bit mode. Under back-pressure, a state that drifts while ready is low shows up as changing data or a dropped valid on the very next cycle.

// File: rtl/twg_pkg.sv
package twg_pkg;
  localparam logic [7:0] BYTE_REP = 8'hF3;
  localparam logic [7:0] BYTE_ESC = 8'h0F;
  localparam logic [7:0] BYTE_GRP = 8'hAE;
  localparam logic [2:0] REG_TW   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAY  = 2'd1,
    ST_IPK  = 2'd2,
    ST_FIN  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  typedef struct packed {
    logic hit;
    logic illegal;
    logic traceOn;
  } decodeInfo_t;
endpackage

// File: rtl/twg_datapath.sv
module twg_datapath
  import twg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        opByte0,
  input  logic [7:0]        opByte1,
  input  logic [7:0]        opByte2,
  input  logic [2:0]        modrmReg,
  input  logic              rexW,
  input  logic              opsizePfx,
  input  logic              lockPfx,
  input  logic              mode64,
  input  logic              featEn,
  input  logic              trigEn,
  input  logic              ctxEn,
  input  logic              filtEn,
  input  logic              twEn,
  input  logic              fupOnTw,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] instPtr,
  output decodeInfo_t       decode,
  output logic [DATA_W-1:0] payReg,
  output logic              sizeReg,
  output logic              ipFlagReg,
  output logic [ADDR_W-1:0] ipAddrReg,
  output logic              faultReg
);
  localparam int HALF_W = DATA_W / 2;

  logic              wide;
  logic [DATA_W-1:0] payNext;

  always_comb begin
    decode.hit     = (opByte0 == BYTE_REP) && (opByte1 == BYTE_ESC) &&
                     (opByte2 == BYTE_GRP) && (modrmReg == REG_TW);
    decode.illegal = lockPfx || opsizePfx || !featEn;
    decode.traceOn = trigEn && ctxEn && filtEn && twEn;
    wide           = rexW && mode64;
    payNext        = wide ? operand : {{(DATA_W-HALF_W){1'b0}}, operand[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payReg    <= '0;
      sizeReg   <= 1'b0;
      ipFlagReg <= 1'b0;
      ipAddrReg <= '0;
      faultReg  <= 1'b0;
    end else if (strobe.load) begin
      payReg    <= payNext;
      sizeReg   <= wide;
      ipFlagReg <= fupOnTw;
      ipAddrReg <= instPtr;
      faultReg  <= decode.illegal;
    end
  end
endmodule

// File: rtl/twg_control.sv
module twg_control
  import twg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  decodeInfo_t decode,
  input  logic        ipFlagReg,
  input  logic        faultReg,
  input  logic        pktReady,
  input  logic        ipReady,
  output ctrlStrobe_t strobe,
  output logic        pktValid,
  output logic        ipValid,
  output logic        done,
  output logic        udFault
);
  seqState_t state, stateNext;

  always_comb begin
    strobe.load = (state == ST_IDLE) && instValid && decode.hit;
    stateNext   = state;
    unique case (state)
      ST_IDLE: if (strobe.load) begin
        if (decode.illegal)      stateNext = ST_FIN;
        else if (decode.traceOn) stateNext = ST_PAY;
        else                     stateNext = ST_FIN;
      end
      ST_PAY:  if (pktReady) stateNext = ipFlagReg ? ST_IPK : ST_FIN;
      ST_IPK:  if (ipReady)  stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign pktValid = (state == ST_PAY);
  assign ipValid  = (state == ST_IPK);
  assign done     = (state == ST_FIN);
  assign udFault  = done && faultReg;
endmodule

// File: rtl/trace_write_gate.sv
module trace_write_gate
  import twg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [7:0]        opByte0,
  input  logic [7:0]        opByte1,
  input  logic [7:0]        opByte2,
  input  logic [2:0]        modrmReg,
  input  logic              rexW,
  input  logic              opsizePfx,
  input  logic              lockPfx,
  input  logic              mode64,
  input  logic              featEn,
  input  logic              trigEn,
  input  logic              ctxEn,
  input  logic              filtEn,
  input  logic              twEn,
  input  logic              fupOnTw,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] instPtr,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [DATA_W-1:0] pktData,
  output logic              pktSize,
  output logic              pktIpFlag,
  output logic              ipValid,
  input  logic              ipReady,
  output logic [ADDR_W-1:0] ipAddr,
  output logic              done,
  output logic              udFault
);
  ctrlStrobe_t strobe;
  decodeInfo_t decode;
  logic        faultReg;

  twg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opByte0(opByte0), .opByte1(opByte1), .opByte2(opByte2), .modrmReg(modrmReg),
    .rexW(rexW), .opsizePfx(opsizePfx), .lockPfx(lockPfx), .mode64(mode64),
    .featEn(featEn), .trigEn(trigEn), .ctxEn(ctxEn), .filtEn(filtEn), .twEn(twEn),
    .fupOnTw(fupOnTw), .operand(operand), .instPtr(instPtr),
    .decode(decode), .payReg(pktData), .sizeReg(pktSize), .ipFlagReg(pktIpFlag),
    .ipAddrReg(ipAddr), .faultReg(faultReg)
  );

  twg_control uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .decode(decode),
    .ipFlagReg(pktIpFlag), .faultReg(faultReg), .pktReady(pktReady), .ipReady(ipReady),
    .strobe(strobe), .pktValid(pktValid), .ipValid(ipValid), .done(done), .udFault(udFault)
  );
endmodule

// File: rtl/twg_checker.sv
module twg_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              pktValid,
  input logic              pktReady,
  input logic [DATA_W-1:0] pktData,
  input logic              pktSize,
  input logic              pktIpFlag,
  input logic              ipValid,
  input logic              ipReady,
  input logic [ADDR_W-1:0] ipAddr,
  input logic              done,
  input logic              udFault
);
  localparam int HALF_W = DATA_W / 2;

  assert_fault_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    udFault |-> done);
  assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktSize) |-> (pktData[DATA_W-1:HALF_W] == '0));
  assert_pkt_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktData) && $stable(pktSize) && $stable(pktIpFlag)));
  assert_ip_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ipValid && !ipReady) |=> (ipValid && $stable(ipAddr)));
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(pktValid && ipValid));
  assert_ip_after_pkt_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ipValid) |-> $past(pktValid && pktReady && pktIpFlag));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(pktValid || ipValid));
endmodule

bind trace_write_gate twg_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktReady(pktReady), .pktData(pktData),
  .pktSize(pktSize), .pktIpFlag(pktIpFlag), .ipValid(ipValid), .ipReady(ipReady),
  .ipAddr(ipAddr), .done(done), .udFault(udFault)
);

// File: tb/tb_trace_write_gate.sv
`timescale 1ns/1ps
module tb_trace_write_gate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [7:0] opByte0 = 8'hF3, opByte1 = 8'h0F, opByte2 = 8'hAE;
  logic [2:0] modrmReg = 3'd4;
  logic rexW = 0, opsizePfx = 0, lockPfx = 0, mode64 = 1, featEn = 1;
  logic trigEn = 1, ctxEn = 1, filtEn = 1, twEn = 1, fupOnTw = 0;
  logic [63:0] operand = '0, instPtr = '0;
  logic pktValid, pktReady = 1'b1, pktSize, pktIpFlag, ipValid, ipReady = 1'b1, done, udFault;
  logic [63:0] pktData, ipAddr;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  trace_write_gate dut (.*);

  // results of the last run
  int nPkt, nIp, nDone, cyc;
  logic gotFault, orderBad;
  logic [63:0] gotData, gotAddr;
  logic gotSize, gotFlag;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runInst(input int stallCycles, input int maxCycles);
    nPkt = 0; nIp = 0; nDone = 0; gotFault = 0; orderBad = 0; cyc = 0;
    @(negedge clk);
    instValid = 1'b1;
    pktReady  = (stallCycles == 0);
    ipReady   = (stallCycles == 0);
    for (int i = 0; i < maxCycles; i++) begin
      @(negedge clk);
      cyc = i + 1;
      if (i + 1 >= stallCycles) begin pktReady = 1'b1; ipReady = 1'b1; end
      if (pktValid && pktReady) begin
        nPkt++; gotData = pktData; gotSize = pktSize; gotFlag = pktIpFlag;
      end
      if (ipValid && ipReady) begin
        if (nPkt == 0) orderBad = 1;
        nIp++; gotAddr = ipAddr;
      end
      if (pktValid && pktReady && !(i + 1 >= stallCycles)) orderBad = 1;
      if (done) begin
        nDone++; gotFault = udFault; instValid = 1'b0;
        break;
      end
    end
    instValid = 1'b0;
    pktReady = 1'b1; ipReady = 1'b1;
    @(negedge clk);
    if (done) nDone++;
  endtask

  task automatic setLegal();
    opByte0 = 8'hF3; opByte1 = 8'h0F; opByte2 = 8'hAE; modrmReg = 3'd4;
    rexW = 0; opsizePfx = 0; lockPfx = 0; mode64 = 1; featEn = 1;
    trigEn = 1; ctxEn = 1; filtEn = 1; twEn = 1; fupOnTw = 0;
  endtask

  task automatic testReset();
    check("R9 pktValid", pktValid, 0);
    check("R9 ipValid", ipValid, 0);
    check("R9 done", done, 0);
    check("R9 udFault", udFault, 0);
  endtask

  task automatic testNarrow();
    setLegal(); operand = 64'hDEAD_BEEF_1234_5678;
    runInst(0, 20);
    check("R2 narrow pkt count", nPkt, 1);
    check("R2 narrow size", gotSize, 0);
    check("R2 narrow data", gotData, 64'h0000_0000_1234_5678);
    check("R8 single done", nDone, 1);
    check("R8 done after accept cycles", cyc, 2);
  endtask

  task automatic testWide();
    setLegal(); rexW = 1; operand = 64'hA5A5_0001_C3C3_0002;
    runInst(0, 20);
    check("R2 wide size", gotSize, 1);
    check("R2 wide data", gotData, 64'hA5A5_0001_C3C3_0002);
  endtask

  task automatic testRexLegacy();
    setLegal(); rexW = 1; mode64 = 0; operand = 64'hFFFF_FFFF_0BAD_F00D;
    runInst(0, 20);
    check("R2 legacy rexW size", gotSize, 0);
    check("R2 legacy rexW data", gotData, 64'h0000_0000_0BAD_F00D);
  endtask

  task automatic testGating();
    for (int k = 0; k < 4; k++) begin
      setLegal();
      case (k)
        0: trigEn = 0;
        1: ctxEn = 0;
        2: filtEn = 0;
        default: twEn = 0;
      endcase
      runInst(0, 20);
      check("R3 gated no pkt", nPkt, 0);
      check("R3 gated done", nDone, 1);
      check("R3 gated no fault", gotFault, 0);
      check("R8 gated done cycles", cyc, 1);
    end
  endtask

  task automatic testFup();
    setLegal(); fupOnTw = 1; operand = 64'h1111; instPtr = 64'h0000_7FFF_0040_1000;
    runInst(3, 30);
    check("R6 flag", gotFlag, 1);
    check("R6 ip count", nIp, 1);
    check("R6 ip addr", gotAddr, 64'h0000_7FFF_0040_1000);
    check("R6 order", orderBad, 0);
    check("R7 stalled pkt delivered", nPkt, 1);
    setLegal(); fupOnTw = 0;
    runInst(0, 20);
    check("R6 flag off", gotFlag, 0);
    check("R6 no ip", nIp, 0);
  endtask

  task automatic testFaults();
    for (int k = 0; k < 3; k++) begin
      setLegal();
      case (k)
        0: lockPfx = 1;
        1: opsizePfx = 1;
        default: featEn = 0;
      endcase
      runInst(0, 20);
      check("R4 fault raised", gotFault, 1);
      check("R5 fault no pkt", nPkt, 0);
      check("R5 fault no ip", nIp, 0);
    end
    setLegal(); fupOnTw = 1; lockPfx = 1;
    runInst(0, 20);
    check("R5 priority no pkt", nPkt + nIp, 0);
  endtask

  task automatic testUnrecognized();
    for (int k = 0; k < 3; k++) begin
      setLegal();
      case (k)
        0: modrmReg = 3'd3;
        1: opByte0 = 8'h66;
        default: opByte2 = 8'hAF;
      endcase
      runInst(0, 8);
      check("R1 unrecognized no done", nDone, 0);
      check("R1 unrecognized no pkt", nPkt, 0);
      check("R1 unrecognized no fault", gotFault, 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNarrow();
    testWide();
    testRexLegacy();
    testGating();
    testFup();
    testFaults();
    testUnrecognized();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule